// File: doc/BRIEF.md
# Bus Target to Push-Pull Bridge

This block sits behind the target side of a host bus core and turns each target transaction into work for the chip's internal units. The core offers one pending transaction at a time through a single-entry address FIFO. It also provides a write data port and a receive FIFO for read data. The bridge decodes which base address register was hit and, for register space, which region was addressed. Accesses to its own four registers finish inside the bridge. Every other access is sent out as a single push/pull command carrying a target code, direction, address, transaction ID and longword count.

Memory writes first collect their burst, up to sixteen longwords, in a staging buffer and only then issue the command. The buffer is then drained over the pull data bus, one word per ID-matched pull cycle. Register writes skip the buffer and feed the core's write word straight onto the pull bus. Read data arriving on the push bus is passed into the receive FIFO in the same cycle that its ID matches.

The address FIFO entry is popped only after the last data word of the transaction has moved. That pop is what tells the core the transaction has finished, so only one command is ever outstanding. Partial-width reads of the scratch region, and hits on the unused fourth BAR, are refused: no command goes out, and the entry is retired with an error flag.

Top module: `tgt_ppb_bridge`

## Requirements
- R1: An issued command's `cmd_tgt` equals the BAR hit: BAR0 gives 00 (register), BAR1 gives 01 (SRAM), BAR2 gives 10 (DRAM). `cmd_wr` and `cmd_addr` equal the transaction's direction and address.
- R2: A BAR0 access with `af_addr[19:16]` = 0 targets one of four local 32-bit registers, selected by `af_addr[3:2]`. It issues no command. Byte i of a local write is updated only when `af_be_n[i]` is 0. All local registers read as 0 after reset.
- R3: A local read raises `rf_we` exactly once, with the register value on `rf_data`, one cycle after the decode cycle. The decode cycle is the first cycle the bridge is idle with `af_valid` high.
- R4: A memory write (BAR1 or BAR2) takes `af_len` beats (1 to 16; 0 or more than 16 means 16) through `wd_valid`/`wd_rdy` into the staging buffer. Its command is issued only after the last beat, with `cmd_cnt` = length. Register commands and memory reads use `cmd_cnt` = 1 and `af_len` respectively.
- R5: `pull_data` is nonzero only in cycles with `pull_valid` high and `pull_id` equal to the outstanding command's ID. A memory write sends the buffered words in beat order, one per matched cycle. A register write sends `wd_data` and raises `wd_rdy` in that cycle.
- R6: During a read, each cycle with `push_valid` high and a matching `push_id` raises `rf_we`, with `rf_data` = `push_data`, in the same cycle. Push cycles with any other ID are ignored.
- R7: `af_pop` pulses for one cycle, exactly one cycle after the last matched data beat of a command transaction. There is at most one outstanding command, and no further address entry is decoded before the pop.
- R8: The first command after reset carries ID 0. Each later command carries the previous ID plus one, modulo 16.
- R9: A BAR0 read with `af_addr[19:16]` = 1 (scratch region) and `af_be_n` not 0000, or any BAR3 access, issues no command. Its entry is popped with `err` high in the pop cycle. A scratch read with `af_be_n` = 0000 is issued normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| af_valid | input | 1 | Address FIFO holds an entry |
| af_bar | input | 2 | BAR hit of the entry (0..3) |
| af_write | input | 1 | Entry is a write |
| af_addr | input | 32 | Target address |
| af_be_n | input | 4 | Active-low byte enables |
| af_len | input | 5 | Burst length in longwords |
| af_pop | output | 1 | Retire (pop) the address entry |
| wd_valid | input | 1 | Core write word valid |
| wd_data | input | 32 | Core write word |
| wd_rdy | output | 1 | Write word consumed this cycle |
| cmd_valid | output | 1 | Command issue strobe |
| cmd_tgt | output | 2 | Command target code |
| cmd_wr | output | 1 | Command direction, 1 = write |
| cmd_addr | output | 32 | Command address |
| cmd_id | output | 4 | Command transaction ID |
| cmd_cnt | output | 5 | Command longword count |
| pull_valid | input | 1 | Pull bus request valid |
| pull_id | input | 4 | Pull bus request ID |
| pull_data | output | 32 | Pull bus write data |
| push_valid | input | 1 | Push bus data valid |
| push_id | input | 4 | Push bus data ID |
| push_data | input | 32 | Push bus read data |
| rf_we | output | 1 | Receive FIFO write strobe |
| rf_data | output | 32 | Receive FIFO write data |
| err | output | 1 | Entry refused (valid with `af_pop`) |

## Verification
`pull_data`, `wd_rdy` for register writes and `rf_we`/`rf_data` for pushes respond in the same cycle as a matched bus beat. `cmd_valid` comes one cycle after the decode cycle or after the last staged write beat. A local read's receive strobe follows the decode cycle by one. `af_pop` comes one cycle after the last matched beat, and for refused entries one cycle after decode. The bench drives inputs right after each falling edge and samples 1 ns later in the same low phase, so every same-cycle response is judged against the inputs that produced it. Pop timing is measured against the cycle counter value recorded at the last matched beat. Random gaps and wrong-ID beats on both data buses check that only matching beats advance the transfer.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LWR,
        ST_LRD,
        ST_ISSUE,
        ST_PULL,
        ST_PUSH,
        ST_RETIRE
    } ppb_st_e;

    typedef enum logic [1:0] {
        TG_REG  = 2'b00,
        TG_SRAM = 2'b01,
        TG_DRAM = 2'b10
    } ppb_tgt_e;
endpackage

// File: rtl/ppb_wbuf.sv
module ppb_wbuf #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ppb_lcsr.sv
module ppb_lcsr #(
    parameter int DW   = 32,
    parameter int NREG = 4,
    localparam int LW  = $clog2(NREG),
    localparam int BW  = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [LW-1:0] widx,
    input  logic [BW-1:0] be_n,
    input  logic [DW-1:0] wdata,
    input  logic [LW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [DW-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (we && widx == LW'(r)) begin
                for (int b = 0; b < BW; b++) begin
                    if (!be_n[b]) val_q[8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
        assign regs[r] = val_q;
    end

    assign rdata = regs[ridx];
endmodule

// File: rtl/tgt_ppb_bridge.sv
module tgt_ppb_bridge
    import ppb_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int IW     = 4,
    parameter int BEATS  = 16,
    parameter int NLOC   = 4,
    parameter int RG_LSB = 16,
    localparam int CW    = $clog2(BEATS) + 1,
    localparam int BW    = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          af_valid,
    input  logic [1:0]    af_bar,
    input  logic          af_write,
    input  logic [AW-1:0] af_addr,
    input  logic [BW-1:0] af_be_n,
    input  logic [CW-1:0] af_len,
    output logic          af_pop,
    input  logic          wd_valid,
    input  logic [DW-1:0] wd_data,
    output logic          wd_rdy,
    output logic          cmd_valid,
    output logic [1:0]    cmd_tgt,
    output logic          cmd_wr,
    output logic [AW-1:0] cmd_addr,
    output logic [IW-1:0] cmd_id,
    output logic [CW-1:0] cmd_cnt,
    input  logic          pull_valid,
    input  logic [IW-1:0] pull_id,
    output logic [DW-1:0] pull_data,
    input  logic          push_valid,
    input  logic [IW-1:0] push_id,
    input  logic [DW-1:0] push_data,
    output logic          rf_we,
    output logic [DW-1:0] rf_data,
    output logic          err
);
    localparam int PW = $clog2(BEATS);
    localparam int LW = $clog2(NLOC);

    typedef struct packed {
        ppb_st_e       st;
        logic [1:0]    tgt;
        logic          wr;
        logic [AW-1:0] addr;
        logic [BW-1:0] be_n;
        logic [CW-1:0] cnt;
        logic [PW-1:0] ptr;
        logic [IW-1:0] tid;
        logic          bad;
        logic [LW-1:0] lidx;
        logic [DW-1:0] lrd;
    } regs_t;

    regs_t q, d;

    logic          buf_we, lc_we;
    logic [DW-1:0] buf_rdata, lc_rdata;
    logic          is_loc, is_scr, refuse, last, pull_hit, push_hit;

    ppb_wbuf #(.DW(DW), .DEPTH(BEATS)) u_wbuf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (q.ptr),
        .wdata (wd_data),
        .raddr (q.ptr),
        .rdata (buf_rdata)
    );

    ppb_lcsr #(.DW(DW), .NREG(NLOC)) u_lcsr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lc_we),
        .widx  (q.lidx),
        .be_n  (q.be_n),
        .wdata (wd_data),
        .ridx  (af_addr[2 +: LW]),
        .rdata (lc_rdata)
    );

    always_comb begin
        is_loc   = (af_bar == 2'd0) && (af_addr[RG_LSB +: 4] == 4'h0);
        is_scr   = (af_bar == 2'd0) && (af_addr[RG_LSB +: 4] == 4'h1);
        refuse   = (af_bar == 2'd3) || (is_scr && !af_write && (af_be_n != '0));
        last     = ({1'b0, q.ptr} == (q.cnt - CW'(1)));
        pull_hit = pull_valid && (pull_id == q.tid);
        push_hit = push_valid && (push_id == q.tid);

        d         = q;
        buf_we    = 1'b0;
        lc_we     = 1'b0;
        wd_rdy    = 1'b0;
        cmd_valid = 1'b0;
        pull_data = '0;
        rf_we     = 1'b0;
        rf_data   = '0;
        af_pop    = 1'b0;
        err       = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (af_valid) begin
                    d.tgt  = af_bar;
                    d.wr   = af_write;
                    d.addr = af_addr;
                    d.be_n = af_be_n;
                    d.ptr  = '0;
                    d.bad  = 1'b0;
                    d.lidx = af_addr[2 +: LW];
                    if (af_bar == 2'd0)
                        d.cnt = CW'(1);
                    else if (af_len == '0 || af_len > CW'(BEATS))
                        d.cnt = CW'(BEATS);
                    else
                        d.cnt = af_len;
                    if (refuse) begin
                        d.bad = 1'b1;
                        d.st  = ST_RETIRE;
                    end else if (is_loc) begin
                        d.lrd = lc_rdata;
                        d.st  = af_write ? ST_LWR : ST_LRD;
                    end else if (af_write && af_bar != 2'd0) begin
                        d.st = ST_LOAD;
                    end else begin
                        d.st = ST_ISSUE;
                    end
                end
            end
            ST_LOAD: begin
                wd_rdy = 1'b1;
                if (wd_valid) begin
                    buf_we = 1'b1;
                    d.ptr  = q.ptr + PW'(1);
                    if (last) begin
                        d.ptr = '0;
                        d.st  = ST_ISSUE;
                    end
                end
            end
            ST_LWR: begin
                wd_rdy = 1'b1;
                if (wd_valid) begin
                    lc_we = 1'b1;
                    d.st  = ST_RETIRE;
                end
            end
            ST_LRD: begin
                rf_we   = 1'b1;
                rf_data = q.lrd;
                d.st    = ST_RETIRE;
            end
            ST_ISSUE: begin
                cmd_valid = 1'b1;
                d.st      = q.wr ? ST_PULL : ST_PUSH;
            end
            ST_PULL: begin
                if (pull_hit) begin
                    pull_data = (q.tgt == TG_REG) ? wd_data : buf_rdata;
                    wd_rdy    = (q.tgt == TG_REG);
                    d.ptr     = q.ptr + PW'(1);
                    if (last) begin
                        d.tid = q.tid + IW'(1);
                        d.st  = ST_RETIRE;
                    end
                end
            end
            ST_PUSH: begin
                if (push_hit) begin
                    rf_we   = 1'b1;
                    rf_data = push_data;
                    d.ptr   = q.ptr + PW'(1);
                    if (last) begin
                        d.tid = q.tid + IW'(1);
                        d.st  = ST_RETIRE;
                    end
                end
            end
            ST_RETIRE: begin
                af_pop = 1'b1;
                err    = q.bad;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cmd_tgt  = q.tgt;
    assign cmd_wr   = q.wr;
    assign cmd_addr = q.addr;
    assign cmd_id   = q.tid;
    assign cmd_cnt  = q.cnt;
endmodule

// File: rtl/ppb_chk.sv
module ppb_chk #(
    parameter int IW = 4,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [IW-1:0] cmd_id,
    input logic          af_pop,
    input logic          err,
    input logic          pull_valid,
    input logic [IW-1:0] pull_id,
    input logic [DW-1:0] pull_data
);
    logic [IW-1:0] last_id;
    logic          seen, open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_id <= '0;
            seen    <= 1'b0;
            open    <= 1'b0;
        end else begin
            if (cmd_valid) begin
                last_id <= cmd_id;
                seen    <= 1'b1;
            end
            if (af_pop) open <= 1'b0;
            else if (cmd_valid) open <= 1'b1;
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !open); // R7
    AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        af_pop |=> !af_pop); // R7
    AST_PULL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_data != '0) |-> (seen && pull_valid && pull_id == last_id)); // R5
    AST_REFUSE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (af_pop && !open && !cmd_valid)); // R9
    AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && seen) |-> (cmd_id == last_id + IW'(1))); // R8
    AST_FIRST_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !seen) |-> (cmd_id == '0)); // R8
endmodule

bind tgt_ppb_bridge ppb_chk #(.IW(IW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_id     (cmd_id),
    .af_pop     (af_pop),
    .err        (err),
    .pull_valid (pull_valid),
    .pull_id    (pull_id),
    .pull_data  (pull_data)
);

// File: tb/tgt_ppb_bridge_tb.sv
module tgt_ppb_bridge_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        af_valid = 1'b0;
    logic [1:0]  af_bar = '0;
    logic        af_write = 1'b0;
    logic [31:0] af_addr = '0;
    logic [3:0]  af_be_n = '0;
    logic [4:0]  af_len = '0;
    logic        af_pop;
    logic        wd_valid = 1'b0;
    logic [31:0] wd_data = '0;
    logic        wd_rdy;
    logic        cmd_valid;
    logic [1:0]  cmd_tgt;
    logic        cmd_wr;
    logic [31:0] cmd_addr;
    logic [3:0]  cmd_id;
    logic [4:0]  cmd_cnt;
    logic        pull_valid = 1'b0;
    logic [3:0]  pull_id = '0;
    logic [31:0] pull_data;
    logic        push_valid = 1'b0;
    logic [3:0]  push_id = '0;
    logic [31:0] push_data = '0;
    logic        rf_we;
    logic [31:0] rf_data;
    logic        err;

    tgt_ppb_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .af_valid(af_valid), .af_bar(af_bar), .af_write(af_write), .af_addr(af_addr),
        .af_be_n(af_be_n), .af_len(af_len), .af_pop(af_pop),
        .wd_valid(wd_valid), .wd_data(wd_data), .wd_rdy(wd_rdy),
        .cmd_valid(cmd_valid), .cmd_tgt(cmd_tgt), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
        .cmd_id(cmd_id), .cmd_cnt(cmd_cnt),
        .pull_valid(pull_valid), .pull_id(pull_id), .pull_data(pull_data),
        .push_valid(push_valid), .push_id(push_id), .push_data(push_data),
        .rf_we(rf_we), .rf_data(rf_data), .err(err)
    );

    int nvec = 0;
    int nbad = 0;
    int cyc = 0;
    int tid_m = 0;
    logic [31:0] lreg [4];
    logic [31:0] wdat [16];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nvec++;
        nbad++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    function automatic logic [1:0] exp_tgt(input logic [1:0] bar);
        return bar;
    endfunction

    task automatic fill_data();
        for (int i = 0; i < 16; i++) wdat[i] = $urandom;
    endtask

    task automatic idle_inputs();
        af_valid = 1'b0;
        wd_valid = 1'b0;
        pull_valid = 1'b0;
        push_valid = 1'b0;
    endtask

    task automatic run_txn(input logic [1:0] bar, input bit wr, input logic [31:0] addr,
                           input logic [3:0] ben, input int len);
        bit is_loc = (bar == 2'd0) && (addr[19:16] == 4'h0);
        bit is_bad = (bar == 2'd3) || ((bar == 2'd0) && (addr[19:16] == 4'h1) && !wr && ben != 4'h0);
        bit mem = (bar == 2'd1) || (bar == 2'd2);
        int nbeat = mem ? len : 1;
        int expcmd = (is_loc || is_bad) ? 0 : 1;
        int wlim = wr ? nbeat : 0;
        int ridx = int'(addr[3:2]);
        int wi = 0;
        int pk = 0;
        int ncmd = 0;
        int rfn = 0;
        int lastb = -100;
        int t0 = 0;
        int guard = 0;
        bit take = 0;
        bit done = 0;
        bit seen = 0;
        logic [3:0] cid = '0;
        af_valid = 1'b1;
        af_bar = bar;
        af_write = wr;
        af_addr = addr;
        af_be_n = ben;
        af_len = len[4:0];
        while (!done && guard < 400) begin
            if (guard > 0) @(negedge clk);
            if (take) wi++;
            take = 0;
            wd_valid = (wi < wlim) && (!mem || ($urandom % 4) != 0);
            wd_data = wdat[(wi < 16) ? wi : 0];
            pull_valid = 1'b0;
            push_valid = 1'b0;
            if (seen && pk < nbeat) begin
                int r = int'($urandom % 4);
                if (r != 0) begin
                    if (wr) begin
                        pull_valid = 1'b1;
                        pull_id = (r == 1) ? (cid ^ 4'h5) : cid;
                    end else begin
                        push_valid = 1'b1;
                        push_id = (r == 1) ? (cid ^ 4'h5) : cid;
                        push_data = $urandom;
                    end
                end
            end
            #1;
            if (guard == 0) t0 = cyc;
            guard++;
            if (cmd_valid) begin
                chk("R1 command target", cmd_tgt, exp_tgt(bar));
                chk("R1 command direction", cmd_wr, wr);
                chk("R1 command address", cmd_addr, addr);
                chk("R8 command id", cmd_id, tid_m % 16);
                chk("R4 command count", cmd_cnt, nbeat);
                chk("R4 buffer filled before command", wi, (mem && wr) ? len : 0);
                ncmd++;
                seen = 1;
                cid = cmd_id;
            end
            take = wd_valid && wd_rdy;
            if (pull_valid) begin
                if (pull_id == cid) begin
                    chk("R5 pull word", pull_data, mem ? wdat[pk] : wdat[0]);
                    if (!mem) chk("R5 register write word taken", wd_rdy, 1);
                    pk++;
                    lastb = cyc;
                end else begin
                    chk("R5 mismatched pull quiet", pull_data, 0);
                end
            end
            if (push_valid) begin
                if (push_id == cid) begin
                    chk("R6 push strobe", rf_we, 1);
                    chk("R6 push data", rf_data, push_data);
                    pk++;
                    lastb = cyc;
                end else begin
                    chk("R6 mismatched push ignored", rf_we, 0);
                end
            end
            if (is_loc && !wr && rf_we) begin
                chk("R3 local read data", rf_data, lreg[ridx]);
                chk("R3 local read latency", cyc - t0, 1);
                rfn++;
            end
            if (af_pop) begin
                done = 1;
                chk("R9 error flag at pop", err, is_bad);
                chk("R7 commands per entry", ncmd, expcmd);
                if (expcmd == 1) begin
                    chk("R7 pop one cycle after last beat", cyc - lastb, 1);
                    chk("R7 all beats before pop", pk, nbeat);
                end
                if (is_loc) chk("R2 local access issues no command", ncmd, 0);
                if (is_loc && !wr) chk("R3 single receive write", rfn, 1);
                if (is_bad) chk("R9 refused entry consumed no data", wi, 0);
            end else if (err) begin
                chk("R9 error only with pop", err, 0);
            end
        end
        if (!done) chk("R7 entry retired", 0, 1);
        if (is_loc && wr) begin
            for (int b = 0; b < 4; b++)
                if (!ben[b]) lreg[ridx][8*b +: 8] = wdat[0][8*b +: 8];
        end
        if (expcmd == 1) tid_m++;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'h1d2c3b4a));
        for (int i = 0; i < 4; i++) lreg[i] = '0;
        fill_data();
        repeat (3) @(negedge clk);
        #1;
        chk("R7 reset pop low", af_pop, 0);
        chk("R7 reset command low", cmd_valid, 0);
        chk("R6 reset receive strobe low", rf_we, 0);
        chk("R9 reset error low", err, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset value and local writes with byte masks, observed by reading back
        run_txn(2'd0, 1'b0, 32'h0000_0004, 4'h0, 1);
        fill_data(); run_txn(2'd0, 1'b1, 32'h0000_0008, 4'h0, 1);
        run_txn(2'd0, 1'b0, 32'h0000_0008, 4'h0, 1);
        fill_data(); run_txn(2'd0, 1'b1, 32'h0000_0008, 4'b1010, 1);
        run_txn(2'd0, 1'b0, 32'h0000_0008, 4'h0, 1);
        fill_data(); run_txn(2'd0, 1'b1, 32'h0000_000C, 4'hF, 1);
        run_txn(2'd0, 1'b0, 32'h0000_000C, 4'h0, 1);
        // external register write and read
        fill_data(); run_txn(2'd0, 1'b1, 32'h0003_0010, 4'h0, 1);
        run_txn(2'd0, 1'b0, 32'h0003_0014, 4'h0, 1);
        // R9 scratch read rules and unused BAR
        run_txn(2'd0, 1'b0, 32'h0001_0020, 4'h0, 1);
        run_txn(2'd0, 1'b0, 32'h0001_0020, 4'b0001, 1);
        fill_data(); run_txn(2'd0, 1'b1, 32'h0001_0024, 4'b0011, 1);
        run_txn(2'd3, 1'b0, 32'h0000_1000, 4'h0, 4);
        fill_data(); run_txn(2'd3, 1'b1, 32'h0000_1000, 4'h0, 4);
        // R4 burst boundaries
        fill_data(); run_txn(2'd1, 1'b1, 32'h0000_0100, 4'h0, 1);
        fill_data(); run_txn(2'd2, 1'b1, 32'h0040_0000, 4'h0, 16);
        run_txn(2'd1, 1'b0, 32'h0000_0200, 4'h0, 16);
        run_txn(2'd2, 1'b0, 32'h0000_0300, 4'h0, 1);

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            logic [1:0]  bar = 2'($urandom % 4);
            bit          wr = bit'($urandom % 2);
            logic [31:0] addr = $urandom & 32'hFFF3_FFFC;
            logic [3:0]  ben = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
            int          len = int'($urandom % 16) + 1;
            fill_data();
            run_txn(bar, wr, addr, ben, len);
        end

        summary();
        $finish;
    end
endmodule